// File: doc/BRIEF.md
# Selectable-Period Serial Watchdog

This block is a watchdog counter that software keeps alive over a serial register write. The written word holds four kinds of field. A 2-bit period code chooses one of four timeout lengths, counted in millisecond ticks. A refresh bit restarts the count, but only when its value differs from the last stored value. Two overtemperature latch-disable bits are stored for a neighbouring protection block to use. The watchdog ignores those two bits.

The count advances by one on each millisecond tick pulse. If the count reaches the active limit before a refresh toggle arrives, the block enters its expired state and raises a sticky timeout flag. A new period code is picked up only by a write that also toggles the refresh bit. This lets the new period start on a fresh count sequence.

The control is a two-state machine. **S_RUN** counts ticks. **S_EXPIRED** holds the count at the limit with the timeout flag raised. The transitions are:
- **T_EXPIRE**: S_RUN to S_EXPIRED, when a tick arrives while the count is one below the limit.
- **T_REFRESH**: S_RUN or S_EXPIRED to S_RUN, on a toggle write. It clears the count and loads the period code.
- **T_HOLD**: the state is kept in every other cycle.

Reset enters S_RUN with a count of zero and period code 00.

Top module: `sel_period_wdog`

## Requirements
- R1: After reset the outputs read as follows: timeout is 0, count is 0, period code is 00, overtemperature latch-disable bits are 00. The stored refresh bit is 0.
- R2: Period codes map to limits as follows: 00 to P0 (default 2250), 01 to P1 (1125), 10 to P2 (558), 11 to P3 (279). The timeout flag rises in the cycle after the tick that brings the count to the active limit, and not earlier.
- R3: In S_RUN the count rises by exactly one in the cycle after each ms_tick. It holds when there is no tick.
- R4: A toggle write sets the count to 0 and clears the timeout flag in the next cycle. A toggle write is wr_en high with wr_data[2] different from the stored refresh bit.
- R5: A toggle write makes wr_data[1:0] of the same write the active period code.
- R6: A write with an unchanged refresh bit neither restarts the count nor changes the active period code.
- R7: The timeout flag stays high until a toggle write. While it is high, the count stays at the limit whatever ticks arrive.
- R8: When a toggle write and a tick fall in the same cycle, the toggle wins and the count becomes 0.
- R9: Every write, toggle or not, stores wr_data[4:3] on ot_nolatch. Those bits have no effect on the count, the timeout flag or the period code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Written word: [1:0] period code, [2] refresh, [4:3] latch-disable |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| wd_timeout | output | 1 | Sticky timeout flag |
| wd_count | output | CNT_W | Ticks counted since the last restart |
| wd_sel | output | 2 | Active period code |
| ot_nolatch | output | 2 | Stored overtemperature latch-disable bits |

## Verification
The bench builds the block with period limits of 24, 12, 7 and 4 ticks instead of the millisecond defaults. With these limits, every code can be run to expiry and past it many times within a short run. Each limit is exercised at its exact threshold, and the saturated expired state is held under further ticks. Random writes then mix toggles, non-toggle writes and simultaneous ticks. This puts refresh-versus-tick collisions and ignored period changes within reach in every period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [0:0] {
        S_RUN     = 1'b0,
        S_EXPIRED = 1'b1
    } wd_state_e;

    localparam int WD_SEL_W   = 2;
    localparam int WD_SEL_LSB = 0;
    localparam int WD_REF_BIT = 2;
    localparam int WD_OT_LSB  = 3;
    localparam int WD_OT_W    = 2;
    localparam int WD_WR_W    = WD_OT_LSB + WD_OT_W;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
    import wdog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WD_WR_W-1:0]   wr_data,
    output logic                 restart,
    output logic [WD_SEL_W-1:0]  new_sel,
    output logic [WD_OT_W-1:0]   ot_nolatch,
    output logic                 refresh_q
);

    logic wr_ref;

    assign wr_ref  = wr_data[WD_REF_BIT];
    assign new_sel = wr_data[WD_SEL_LSB +: WD_SEL_W];
    assign restart = wr_en && (wr_ref != refresh_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_q  <= 1'b0;
            ot_nolatch <= '0;
        end else if (wr_en) begin
            refresh_q  <= wr_ref;
            ot_nolatch <= wr_data[WD_OT_LSB +: WD_OT_W];
        end
    end

endmodule

// File: rtl/wdog_limit.sv
module wdog_limit
    import wdog_pkg::*;
#(
    parameter int unsigned P0    = 2250,
    parameter int unsigned P1    = 1125,
    parameter int unsigned P2    = 558,
    parameter int unsigned P3    = 279,
    parameter int          CNT_W = 12
) (
    input  logic [WD_SEL_W-1:0] sel,
    output logic [CNT_W-1:0]    limit
);

    localparam int NSEL = 1 << WD_SEL_W;
    localparam int unsigned PTAB [NSEL] = '{P0, P1, P2, P3};

    logic [CNT_W-1:0] table_w [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_tab
        assign table_w[g] = CNT_W'(PTAB[g]);
    end

    assign limit = table_w[sel];

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [WD_SEL_W-1:0] new_sel,
    input  logic                ms_tick,
    input  logic [CNT_W-1:0]    limit,
    output logic [WD_SEL_W-1:0] sel_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                timeout
);

    wd_state_e             state_q, state_d;
    logic [CNT_W-1:0]      cnt_d;
    logic [WD_SEL_W-1:0]   sel_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sel_d   = sel_q;
        if (restart) begin
            state_d = S_RUN;
            cnt_d   = '0;
            sel_d   = new_sel;
        end else begin
            unique case (state_q)
                S_RUN: begin
                    if (ms_tick) begin
                        if (cnt_q == limit - CNT_W'(1)) begin
                            state_d = S_EXPIRED;
                            cnt_d   = limit;
                        end else begin
                            cnt_d   = cnt_q + CNT_W'(1);
                        end
                    end
                end
                S_EXPIRED: begin
                    cnt_d = cnt_q;
                end
                default: state_d = S_RUN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_EXPIRED: timeout = 1'b1;
            default:   timeout = 1'b0;
        endcase
    end

endmodule

// File: rtl/sel_period_wdog.sv
module sel_period_wdog
    import wdog_pkg::*;
#(
    parameter int unsigned P0 = 2250,
    parameter int unsigned P1 = 1125,
    parameter int unsigned P2 = 558,
    parameter int unsigned P3 = 279,
    localparam int CNT_W = $clog2(max_of4(P0, P1, P2, P3) + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WD_WR_W-1:0]   wr_data,
    input  logic                 ms_tick,
    output logic                 wd_timeout,
    output logic [CNT_W-1:0]     wd_count,
    output logic [WD_SEL_W-1:0]  wd_sel,
    output logic [WD_OT_W-1:0]   ot_nolatch
);

    logic                restart;
    logic [WD_SEL_W-1:0] new_sel;
    logic                refresh_q;
    logic [CNT_W-1:0]    limit;

    wdog_regif u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .restart    (restart),
        .new_sel    (new_sel),
        .ot_nolatch (ot_nolatch),
        .refresh_q  (refresh_q)
    );

    wdog_limit #(.P0(P0), .P1(P1), .P2(P2), .P3(P3), .CNT_W(CNT_W)) u_limit (
        .sel   (wd_sel),
        .limit (limit)
    );

    wdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .new_sel (new_sel),
        .ms_tick (ms_tick),
        .limit   (limit),
        .sel_q   (wd_sel),
        .cnt_q   (wd_count),
        .timeout (wd_timeout)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
#(
    parameter int unsigned P0 = 2250,
    parameter int unsigned P1 = 1125,
    parameter int unsigned P2 = 558,
    parameter int unsigned P3 = 279,
    localparam int CNT_W = $clog2(max_of4(P0, P1, P2, P3) + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                wr_ref,
    input logic [WD_SEL_W-1:0] wr_sel,
    input logic                ms_tick,
    input logic                wd_timeout,
    input logic [CNT_W-1:0]    wd_count,
    input logic [WD_SEL_W-1:0] wd_sel,
    input logic                refresh_q
);

    logic             tog;
    logic [CNT_W-1:0] lim;

    assign tog = wr_en && (wr_ref != refresh_q);

    always_comb begin
        unique case (wd_sel)
            2'd0:    lim = CNT_W'(P0);
            2'd1:    lim = CNT_W'(P1);
            2'd2:    lim = CNT_W'(P2);
            default: lim = CNT_W'(P3);
        endcase
    end

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wd_count <= lim);

    p_rise_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_timeout) |-> wd_count == lim);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tog && ms_tick && !wd_timeout) |=> wd_count == $past(wd_count) + CNT_W'(1));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tog && !ms_tick) |=> $stable(wd_count) && $stable(wd_timeout));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tog |=> (wd_count == '0) && !wd_timeout);

    p_load_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tog |=> wd_sel == $past(wr_sel));

    p_keep_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tog |=> $stable(wd_sel));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_timeout && !tog) |=> wd_timeout && $stable(wd_count));

endmodule

bind sel_period_wdog wdog_checker #(.P0(P0), .P1(P1), .P2(P2), .P3(P3)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_ref     (wr_data[wdog_pkg::WD_REF_BIT]),
    .wr_sel     (wr_data[wdog_pkg::WD_SEL_LSB +: wdog_pkg::WD_SEL_W]),
    .ms_tick    (ms_tick),
    .wd_timeout (wd_timeout),
    .wd_count   (wd_count),
    .wd_sel     (wd_sel),
    .refresh_q  (refresh_q)
);

// File: tb/sim_sel_period_wdog.sv
`timescale 1ns/1ps
module sim_sel_period_wdog;

    localparam int unsigned L0 = 24, L1 = 12, L2 = 7, L3 = 4;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_data = '0;
    logic          ms_tick = 1'b0;
    logic          wd_timeout;
    logic [CW-1:0] wd_count;
    logic [1:0]    wd_sel;
    logic [1:0]    ot_nolatch;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state
    bit        m_ref;
    bit [1:0]  m_sel;
    int        m_cnt;
    bit        m_to;
    bit [1:0]  m_ot;

    always #5 clk = ~clk;

    sel_period_wdog #(.P0(L0), .P1(L1), .P2(L2), .P3(L3)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ms_tick(ms_tick),
        .wd_timeout(wd_timeout), .wd_count(wd_count), .wd_sel(wd_sel), .ot_nolatch(ot_nolatch)
    );

    function automatic int lim_of(input bit [1:0] s);
        case (s)
            2'd0:    return L0;
            2'd1:    return L1;
            2'd2:    return L2;
            default: return L3;
        endcase
    endfunction

    function automatic bit is_toggle(input bit we, input bit [4:0] d, input bit r);
        return we && (d[2] != r);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ref = 0; m_sel = 0; m_cnt = 0; m_to = 0; m_ot = 0;
    endtask

    task automatic model_step(input bit we, input bit [4:0] d, input bit tk);
        if (is_toggle(we, d, m_ref)) begin        // R4 R5 R8
            m_cnt = 0; m_to = 0; m_sel = d[1:0];
        end else if (!m_to && tk) begin            // R3 R2
            m_cnt++;
            if (m_cnt == lim_of(m_sel)) m_to = 1;
        end
        if (we) begin                              // R9
            m_ref = d[2];
            m_ot  = d[4:3];
        end
    endtask

    task automatic compare_all();
        chk("R3 count",    int'(wd_count),   m_cnt);
        chk("R7 timeout",  int'(wd_timeout), int'(m_to));
        chk("R5 sel",      int'(wd_sel),     int'(m_sel));
        chk("R9 ot bits",  int'(ot_nolatch), int'(m_ot));
    endtask

    // drive at negedge, step model, sample at next negedge
    task automatic cycle(input bit we, input bit [4:0] d, input bit tk);
        wr_en = we; wr_data = d; ms_tick = tk;
        model_step(we, d, tk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; ms_tick = 0;
        compare_all();
    endtask

    task automatic toggle_to(input bit [1:0] s, input bit [1:0] ot);
        cycle(1'b1, {ot, ~m_ref, s}, 1'b0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count",   int'(wd_count),   0);
        chk("R1 timeout", int'(wd_timeout), 0);
        chk("R1 sel",     int'(wd_sel),     0);
        chk("R1 ot",      int'(ot_nolatch), 0);

        // R2 / R7: each code runs to exact threshold
        for (int c = 0; c < 4; c++) begin
            toggle_to(2'(c), 2'b00);
            for (int k = 0; k < lim_of(2'(c)) - 1; k++) cycle(1'b0, '0, 1'b1);
            chk("R2 no early timeout", int'(wd_timeout), 0);
            cycle(1'b0, '0, 1'b1);
            chk("R2 timeout at limit", int'(wd_timeout), 1);
            chk("R2 count at limit", int'(wd_count), lim_of(2'(c)));
            repeat (5) cycle(1'b0, '0, 1'b1);
            chk("R7 saturated count", int'(wd_count), lim_of(2'(c)));
            chk("R7 sticky", int'(wd_timeout), 1);
        end

        // R6: non-toggle write with new period ignored
        toggle_to(2'd1, 2'b00);
        repeat (3) cycle(1'b0, '0, 1'b1);
        cycle(1'b1, {2'b00, m_ref, 2'd3}, 1'b0);
        chk("R6 sel kept", int'(wd_sel), 1);
        chk("R6 count kept", int'(wd_count), 3);

        // R8: toggle with tick in same cycle
        repeat (2) cycle(1'b0, '0, 1'b1);
        cycle(1'b1, {2'b00, ~m_ref, 2'd2}, 1'b1);
        chk("R8 toggle wins", int'(wd_count), 0);
        chk("R5 new sel", int'(wd_sel), 2);

        // R9: ot bits stored without touching watchdog
        cycle(1'b0, '0, 1'b1);
        cycle(1'b1, {2'b11, m_ref, 2'd0}, 1'b0);
        chk("R9 ot stored", int'(ot_nolatch), 3);
        chk("R9 count unaffected", int'(wd_count), 1);
        chk("R9 sel unaffected", int'(wd_sel), 2);

        // random mix
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4000; i++) begin
            bit we = ($urandom % 30) == 0;
            bit tk = ($urandom % 2) == 0;
            bit [4:0] d = 5'($urandom);
            cycle(we, d, tk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule